// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Unit

This block sits beside a processor core's exception logic and decides, once per clock, whether the interrupt level offered by the core's priority encoder is accepted. An accepted level above 1 is dispatched directly. The return address and the processor status word go into save registers belonging to that level. The status word gets the new level and the exception-mode flag. The program counter is redirected to that level's own vector.

An accepted level-1 interrupt goes through the general exception path instead. It records a fixed cause code and sets exception mode. It then enters the double, user or kernel exception vector, depending on the exception-mode and user-mode flags in the incoming status word. Every vector can be moved at run time by a vector-base input.

All updates land on the same clock edge and are signalled by a one-cycle accept strobe. When nothing qualifies, every held register keeps its value.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is accepted only when `pend_level_i` is strictly greater than `cint_level_i`.
- R2: An interrupt is accepted only when `pend_level_i` lies between 1 and NLEVEL inclusive. Level 0, and any level above NLEVEL, is never accepted, even with every request bit set and enabled.
- R3: An interrupt is accepted only when the mask of the pending level, ANDed with `intset_i` and `intenable_i`, is nonzero. The mask of level L is the slice `level_mask_i[(L-1)*NIRQ +: NIRQ]`. Bits that belong to other levels do not count.
- R4: On accepting level L > 1, `pc_i` is stored in save-PC slot L, which is `epc_o[(L-1)*XLEN +: XLEN]`. `ps_i` is stored in save-PS slot L, which is `eps_o[(L-2)*XLEN +: XLEN]`.
- R5: On accepting level L > 1, `next_ps_o` equals `ps_i` with bits [3:0] (the interrupt-level field) replaced by L and bit 4 (exception mode) set. All other bits are kept. `next_pc_o` is the level vector at offset 0x100 + L*0x40.
- R6: On accepting level 1, `cause_o` is loaded with 4.
- R7: On accepting level 1 with `ps_i` bit 4 set, a double exception is taken. `pc_i` goes to `depc_o`, save-PC slot 1 is left alone, and `next_pc_o` is the double vector at offset 0x3C0.
- R8: On accepting level 1 with `ps_i` bit 4 clear, `pc_i` goes to save-PC slot 1. `next_pc_o` is the user vector (offset 0x340) when `ps_i` bit 5 is set, and the kernel vector (offset 0x300) otherwise.
- R9: On accepting level 1, `next_ps_o` equals `ps_i` with bit 4 set and every other bit unchanged.
- R10: With relocation enabled, every vector target equals `vecbase_i` plus the vector's offset from the default base.
- R11: `take_o` and all updated outputs appear together in the cycle after the edge on which the inputs qualified. `take_o` is high for exactly that one cycle per accepting edge.
- R12: When no interrupt qualifies (and after reset), `take_o` is low, and `next_pc_o`, `next_ps_o`, `cause_o`, `epc_o`, `eps_o` and `depc_o` keep their previous values (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_level_i | input | 4 | Highest pending interrupt level |
| cint_level_i | input | 4 | Current interrupt level of the core |
| ps_i | input | XLEN | Current processor status word |
| intset_i | input | NIRQ | Raised interrupt request bits |
| intenable_i | input | NIRQ | Interrupt enable bits |
| level_mask_i | input | NLEVEL*NIRQ | Per-level request masks, level 1 in the low slice |
| pc_i | input | XLEN | Current program counter |
| vecbase_i | input | XLEN | Run-time vector base |
| take_o | output | 1 | One-cycle accept strobe |
| next_pc_o | output | XLEN | Redirect target |
| next_ps_o | output | XLEN | Updated status word |
| cause_o | output | 6 | Exception cause register |
| epc_o | output | NLEVEL*XLEN | Save-PC registers, level 1 in the low slice |
| eps_o | output | (NLEVEL-1)*XLEN | Save-PS registers, level 2 in the low slice |
| depc_o | output | XLEN | Double-exception save-PC register |

## Verification
Two functions can act in the same cycle: vector dispatch for a high level, and the exception-mode path, because a level above 1 can arrive while `ps_i` already has exception mode set. The sweep sets every combination of the exception-mode and user-mode bits on every pending level. The judgement is that high levels still reach their own vector and save slots, with no double exception and no cause update. The same sweep combines exception mode and user mode on level 1, and expects the double vector to win over the user vector with the PC landing only in `depc_o`.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int LVL_W       = 4;
    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;
    localparam int CAUSE_W     = 6;
    localparam logic [CAUSE_W-1:0] CAUSE_LVL1 = 6'd4;

    typedef enum logic [1:0] {
        DISP_HIGH,
        DISP_KERNEL,
        DISP_USER,
        DISP_DOUBLE
    } disp_e;
endpackage

// File: rtl/irqd_qualify.sv
module irqd_qualify
    import irqd_pkg::*;
#(
    parameter int NIRQ   = 8,
    parameter int NLEVEL = 6
) (
    input  logic [LVL_W-1:0]       pend_level,
    input  logic [LVL_W-1:0]       cint_level,
    input  logic [NIRQ-1:0]        intset,
    input  logic [NIRQ-1:0]        intenable,
    input  logic [NLEVEL*NIRQ-1:0] level_mask,
    output logic                   take,
    output logic                   high
);
    logic [NLEVEL:1] hit;
    logic            sel_hit;

    for (genvar g = 1; g <= NLEVEL; g++) begin : g_lvl
        assign hit[g] = |(level_mask[(g-1)*NIRQ +: NIRQ] & intset & intenable);
    end

    always_comb begin
        sel_hit = 1'b0;
        for (int i = 1; i <= NLEVEL; i++) begin
            if (pend_level == LVL_W'(i)) sel_hit = hit[i];
        end
    end

    assign take = sel_hit && (pend_level > cint_level);
    assign high = pend_level > LVL_W'(1);
endmodule

// File: rtl/irqd_vector.sv
module irqd_vector
    import irqd_pkg::*;
#(
    parameter int               XLEN           = 32,
    parameter bit               RELOC_EN       = 1'b1,
    parameter logic [XLEN-1:0]  DEF_BASE       = 32'hD000_0000,
    parameter logic [XLEN-1:0]  LVL_VEC_OFS    = 32'h0000_0100,
    parameter logic [XLEN-1:0]  LVL_VEC_STRIDE = 32'h0000_0040,
    parameter logic [XLEN-1:0]  KERNEL_OFS     = 32'h0000_0300,
    parameter logic [XLEN-1:0]  USER_OFS       = 32'h0000_0340,
    parameter logic [XLEN-1:0]  DOUBLE_OFS     = 32'h0000_03C0
) (
    input  disp_e              kind,
    input  logic [LVL_W-1:0]   level,
    input  logic [XLEN-1:0]    vecbase,
    output logic [XLEN-1:0]    target
);
    logic [XLEN-1:0] ofs;

    always_comb begin
        unique case (kind)
            DISP_HIGH:   ofs = LVL_VEC_OFS + XLEN'(level) * LVL_VEC_STRIDE;
            DISP_KERNEL: ofs = KERNEL_OFS;
            DISP_USER:   ofs = USER_OFS;
            default:     ofs = DOUBLE_OFS;
        endcase
    end

    // Relocated target: default - default base + vecbase == vecbase + offset.
    if (RELOC_EN) begin : g_reloc
        assign target = vecbase + ofs;
    end else begin : g_fixed
        assign target = DEF_BASE + ofs;
    end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irqd_pkg::*;
#(
    parameter int               XLEN           = 32,
    parameter int               NIRQ           = 8,
    parameter int               NLEVEL         = 6,
    parameter bit               HAS_DEPC       = 1'b1,
    parameter bit               RELOC_EN       = 1'b1,
    parameter logic [XLEN-1:0]  DEF_BASE       = 32'hD000_0000,
    parameter logic [XLEN-1:0]  LVL_VEC_OFS    = 32'h0000_0100,
    parameter logic [XLEN-1:0]  LVL_VEC_STRIDE = 32'h0000_0040,
    parameter logic [XLEN-1:0]  KERNEL_OFS     = 32'h0000_0300,
    parameter logic [XLEN-1:0]  USER_OFS       = 32'h0000_0340,
    parameter logic [XLEN-1:0]  DOUBLE_OFS     = 32'h0000_03C0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LVL_W-1:0]           pend_level_i,
    input  logic [LVL_W-1:0]           cint_level_i,
    input  logic [XLEN-1:0]            ps_i,
    input  logic [NIRQ-1:0]            intset_i,
    input  logic [NIRQ-1:0]            intenable_i,
    input  logic [NLEVEL*NIRQ-1:0]     level_mask_i,
    input  logic [XLEN-1:0]            pc_i,
    input  logic [XLEN-1:0]            vecbase_i,
    output logic                       take_o,
    output logic [XLEN-1:0]            next_pc_o,
    output logic [XLEN-1:0]            next_ps_o,
    output logic [CAUSE_W-1:0]         cause_o,
    output logic [NLEVEL*XLEN-1:0]     epc_o,
    output logic [(NLEVEL-1)*XLEN-1:0] eps_o,
    output logic [XLEN-1:0]            depc_o
);
    localparam logic [XLEN-1:0] LVL_FIELD = XLEN'((1 << LVL_W) - 1);
    localparam logic [XLEN-1:0] EXCM_MASK = XLEN'(1) << PS_EXCM_BIT;

    typedef struct packed {
        logic                             take;
        logic [XLEN-1:0]                  pc;
        logic [XLEN-1:0]                  ps;
        logic [CAUSE_W-1:0]               cause;
        logic [NLEVEL-1:0][XLEN-1:0]      epc;
        logic [NLEVEL-2:0][XLEN-1:0]      eps;
        logic [XLEN-1:0]                  depc;
    } state_t;

    state_t state_d, state_q;

    logic            take_c;
    logic            high_c;
    disp_e           kind_c;
    logic [XLEN-1:0] target_c;

    irqd_qualify #(
        .NIRQ   (NIRQ),
        .NLEVEL (NLEVEL)
    ) u_qual (
        .pend_level (pend_level_i),
        .cint_level (cint_level_i),
        .intset     (intset_i),
        .intenable  (intenable_i),
        .level_mask (level_mask_i),
        .take       (take_c),
        .high       (high_c)
    );

    always_comb begin
        kind_c = DISP_HIGH;
        if (!high_c) begin
            if (ps_i[PS_EXCM_BIT])    kind_c = DISP_DOUBLE;
            else if (ps_i[PS_UM_BIT]) kind_c = DISP_USER;
            else                      kind_c = DISP_KERNEL;
        end
    end

    irqd_vector #(
        .XLEN           (XLEN),
        .RELOC_EN       (RELOC_EN),
        .DEF_BASE       (DEF_BASE),
        .LVL_VEC_OFS    (LVL_VEC_OFS),
        .LVL_VEC_STRIDE (LVL_VEC_STRIDE),
        .KERNEL_OFS     (KERNEL_OFS),
        .USER_OFS       (USER_OFS),
        .DOUBLE_OFS     (DOUBLE_OFS)
    ) u_vec (
        .kind    (kind_c),
        .level   (pend_level_i),
        .vecbase (vecbase_i),
        .target  (target_c)
    );

    always_comb begin
        state_d      = state_q;
        state_d.take = 1'b0;
        if (take_c) begin
            state_d.take = 1'b1;
            state_d.pc   = target_c;
            if (high_c) begin
                for (int i = 0; i < NLEVEL; i++) begin
                    if (pend_level_i == LVL_W'(i + 1)) state_d.epc[i] = pc_i;
                end
                for (int i = 0; i < NLEVEL - 1; i++) begin
                    if (pend_level_i == LVL_W'(i + 2)) state_d.eps[i] = ps_i;
                end
                state_d.ps = (ps_i & ~LVL_FIELD) | XLEN'(pend_level_i) | EXCM_MASK;
            end else begin
                state_d.cause = CAUSE_LVL1;
                state_d.ps    = ps_i | EXCM_MASK;
                if (kind_c == DISP_DOUBLE && HAS_DEPC) begin
                    state_d.depc = pc_i;
                end else begin
                    state_d.epc[0] = pc_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign take_o    = state_q.take;
    assign next_pc_o = state_q.pc;
    assign next_ps_o = state_q.ps;
    assign cause_o   = state_q.cause;
    assign epc_o     = state_q.epc;
    assign eps_o     = state_q.eps;
    assign depc_o    = state_q.depc;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NLEVEL = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [LVL_W-1:0]           pend_level_i,
    input logic [LVL_W-1:0]           cint_level_i,
    input logic                       take_o,
    input logic [XLEN-1:0]            next_ps_o,
    input logic [CAUSE_W-1:0]         cause_o,
    input logic [NLEVEL*XLEN-1:0]     epc_o,
    input logic [(NLEVEL-1)*XLEN-1:0] eps_o,
    input logic [XLEN-1:0]            depc_o
);
    localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NLEVEL);

    AST_ABOVE_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(pend_level_i) > $past(cint_level_i)); // R1

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(pend_level_i) <= MAX_LVL && $past(pend_level_i) != '0)); // R2

    AST_HIGH_PS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(pend_level_i) > LVL_W'(1))
        |-> (next_ps_o[LVL_W-1:0] == $past(pend_level_i) && next_ps_o[PS_EXCM_BIT])); // R5

    AST_LVL1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(pend_level_i) == LVL_W'(1)) |-> cause_o == CAUSE_LVL1); // R6

    AST_EXCM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> next_ps_o[PS_EXCM_BIT]); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> ($stable(cause_o) && $stable(epc_o) && $stable(eps_o) && $stable(depc_o))); // R12
endmodule

bind irq_dispatch irqd_checker #(
    .XLEN   (XLEN),
    .NLEVEL (NLEVEL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_level_i (pend_level_i),
    .cint_level_i (cint_level_i),
    .take_o       (take_o),
    .next_ps_o    (next_ps_o),
    .cause_o      (cause_o),
    .epc_o        (epc_o),
    .eps_o        (eps_o),
    .depc_o       (depc_o)
);

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN   = 32;
    localparam int NIRQ   = 8;
    localparam int NLEVEL = 6;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [3:0]                 pend_level_i = '0;
    logic [3:0]                 cint_level_i = '0;
    logic [XLEN-1:0]            ps_i = '0;
    logic [NIRQ-1:0]            intset_i = '0;
    logic [NIRQ-1:0]            intenable_i = '0;
    logic [NLEVEL*NIRQ-1:0]     level_mask_i = 48'h20_10_08_04_02_01;
    logic [XLEN-1:0]            pc_i = '0;
    logic [XLEN-1:0]            vecbase_i = '0;
    logic                       take_o;
    logic [XLEN-1:0]            next_pc_o;
    logic [XLEN-1:0]            next_ps_o;
    logic [5:0]                 cause_o;
    logic [NLEVEL*XLEN-1:0]     epc_o;
    logic [(NLEVEL-1)*XLEN-1:0] eps_o;
    logic [XLEN-1:0]            depc_o;

    int checks = 0;
    int fails  = 0;

    irq_dispatch uut (
        .clk (clk), .rst_n (rst_n),
        .pend_level_i (pend_level_i), .cint_level_i (cint_level_i),
        .ps_i (ps_i), .intset_i (intset_i), .intenable_i (intenable_i),
        .level_mask_i (level_mask_i), .pc_i (pc_i), .vecbase_i (vecbase_i),
        .take_o (take_o), .next_pc_o (next_pc_o), .next_ps_o (next_ps_o),
        .cause_o (cause_o), .epc_o (epc_o), .eps_o (eps_o), .depc_o (depc_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected model state
    logic [XLEN-1:0] e_epc [1:NLEVEL];
    logic [XLEN-1:0] e_eps [2:NLEVEL];
    logic [XLEN-1:0] e_depc, e_pc, e_ps;
    logic [5:0]      e_cause;

    task automatic check_all(input string tag, input logic e_take);
        chk({tag, " take"}, XLEN'(take_o), XLEN'(e_take));
        chk({tag, " pc"}, next_pc_o, e_pc);
        chk({tag, " ps"}, next_ps_o, e_ps);
        chk({tag, " cause"}, XLEN'(cause_o), XLEN'(e_cause));
        chk({tag, " depc"}, depc_o, e_depc);
        for (int l = 1; l <= NLEVEL; l++)
            chk({tag, " epc"}, epc_o[(l-1)*XLEN +: XLEN], e_epc[l]);
        for (int l = 2; l <= NLEVEL; l++)
            chk({tag, " eps"}, eps_o[(l-2)*XLEN +: XLEN], e_eps[l]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int it;
        for (int l = 1; l <= NLEVEL; l++) e_epc[l] = '0;
        for (int l = 2; l <= NLEVEL; l++) e_eps[l] = '0;
        e_depc = '0; e_pc = '0; e_ps = '0; e_cause = '0;

        repeat (3) @(negedge clk);
        check_all("R12 reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R12 idle after reset", 1'b0);

        it = 0;
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 8; c++) begin
                for (int pat = 0; pat < 3; pat++) begin
                    for (int v = 0; v < 4; v++) begin
                        logic            inr, e_take;
                        logic [NIRQ-1:0] bitm;
                        logic [XLEN-1:0] ps, pc, vb, ofs;
                        string           tag;
                        it++;
                        inr  = (p >= 1 && p <= NLEVEL);
                        bitm = inr ? NIRQ'(1 << (p - 1)) : '0;
                        ps   = ((XLEN'(it) * 32'h0001_3579) & ~32'h3F)
                             | (XLEN'(v >> 1) << 5) | (XLEN'(v & 1) << 4) | XLEN'((it * 5) & 15);
                        pc   = 32'h4000_0000 + XLEN'(it) * 4;
                        vb   = 32'h1000_0000 + XLEN'(it % 7) * 32'h0001_0000;
                        pend_level_i = 4'(p);
                        cint_level_i = 4'(c);
                        ps_i = ps; pc_i = pc; vecbase_i = vb;
                        case (pat)
                            0: begin intset_i = inr ? bitm : 8'hFF; intenable_i = inr ? bitm : 8'hFF; end
                            1: begin intset_i = 8'hFF; intenable_i = ~bitm; end
                            default: begin intset_i = ~bitm; intenable_i = 8'hFF; end
                        endcase
                        e_take = inr && (p > c) && (pat == 0);
                        if (!inr)          tag = "R2";
                        else if (pat != 0) tag = "R3";
                        else if (p <= c)   tag = "R1";
                        else if (p > 1)    tag = "R4 R5 R10 R11";
                        else if (v[0])     tag = "R6 R7 R9 R10 R11";
                        else               tag = "R6 R8 R9 R10 R11";
                        if (!e_take) tag = {tag, " R12"};
                        if (e_take) begin
                            if (p > 1) begin
                                e_epc[p] = pc;
                                e_eps[p] = ps;
                                e_ps = (ps & ~32'hF) | XLEN'(p) | 32'h10;
                                ofs  = 32'h100 + XLEN'(p) * 32'h40;
                            end else begin
                                e_cause = 6'd4;
                                e_ps    = ps | 32'h10;
                                if (v[0]) begin
                                    e_depc = pc;
                                    ofs    = 32'h3C0;
                                end else begin
                                    e_epc[1] = pc;
                                    ofs = v[1] ? 32'h340 : 32'h300;
                                end
                            end
                            e_pc = vb + ofs;
                        end
                        @(negedge clk);
                        check_all(tag, e_take);
                    end
                end
            end
        end
        pend_level_i = '0;
        @(negedge clk);
        check_all("R11 R12 strobe drop", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule